// File: doc/BRIEF.md
# Approximate Add-Based Floating-Point Multiplier

This block forms an approximate product of two small floating-point operands without a significand multiplier. For normal operands it computes the result sign with one XOR, adds the two exponent fields and removes one bias, and replaces the significand product (1+a)(1+b) with the sum 1+a+b plus a small fixed correction 2^-L. If that sum reaches 2.0, the exponent is incremented and the fraction is shifted right by one bit, and the bit shifted out is dropped. Subnormal inputs are flushed to zero. Overflow saturates to the largest finite magnitude, underflow returns a signed zero, and NaN and infinity are handled for each format.

Three operand layouts are supported. The 2-bit format code travels with each operation: code 0 is an 8-bit value with a 4-bit exponent and a 3-bit fraction (bias 7), code 1 is an 8-bit value with a 5-bit exponent and a 2-bit fraction (bias 15), and codes 2 and 3 are IEEE half precision (bias 15). All three layouts share one fraction adder and one exponent adder. The correction exponent L equals the fraction width k for k ≤ 3, is 3 for k = 4 and is 4 for wider fractions. This gives L = 3, 2 and 4 for codes 0, 1 and 2/3.

Operations enter and leave through valid/ready handshakes. An operation is accepted on a clock edge where in_valid and in_ready are both high. Its result is offered on the next cycle. A result that is not taken stays on the output unchanged until out_ready is high. A new operation can be accepted in the same cycle that the previous result is taken, so back-to-back throughput is one operation per cycle.

Top module: `amul_mul`

## Requirements
- R1: For every result that is not NaN, the result sign is the XOR of the two operand signs. The sign is bit 7 for codes 0/1 and bit 15 for codes 2/3.
- R2: For normal, finite operands, the result exponent is ea+eb−bias and the result fraction is floor((fa/2^k + fb/2^k + 2^-L)·2^k), where L = 3 for code 0, 2 for code 1 and 4 for codes 2/3.
- R3: When 1 + fa/2^k + fb/2^k + 2^-L ≥ 2, the exponent is incremented by one and the significand is halved, with the dropped bits truncated.
- R4: An operand with an all-zero exponent field (zero or subnormal) gives a signed zero result (all bits zero except the R1 sign), unless R7 or R8 applies.
- R5: A biased result exponent above the largest finite code (15 for code 0, 30 for the others) saturates to the largest finite magnitude with the R1 sign: 0x7E for code 0, 0x7B for code 1, 0x7BFF for codes 2/3. For code 0, a result that would land on exponent 15 with fraction 111 also saturates to 0x7E.
- R6: A biased result exponent below 1 gives a signed zero.
- R7: A NaN operand, or infinity times zero, gives the canonical NaN: 0x7F for code 0, 0x7E for code 1, 0x7E00 for codes 2/3. For code 0 only exponent 1111 with fraction 111 is NaN, and code 0 has no infinity. For the other codes, an all-ones exponent with a nonzero fraction is NaN.
- R8: For codes 1/2/3, an infinity (all-ones exponent, zero fraction) times a nonzero non-NaN operand gives infinity with the R1 sign: 0x7C for code 1, 0x7C00 for codes 2/3, with the sign bit set when negative.
- R9: For codes 0 and 1, only operand bits [7:0] are used. Bits [15:8] of the operands are ignored, and bits [15:8] of the result are zero.
- R10: A result is offered exactly one cycle after its operation is accepted. in_ready is high whenever no result is pending or the pending result is being taken.
- R11: While out_valid is high and out_ready is low, out_valid stays high and out_res does not change.
- R12: During and right after reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted this cycle |
| fmt | input | 2 | Layout code: 0 = e4/f3, 1 = e5/f2, 2 and 3 = half precision |
| op_a | input | 16 | First operand; 8-bit layouts use [7:0] |
| op_b | input | 16 | Second operand; 8-bit layouts use [7:0] |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_res | output | 16 | Approximate product in the same layout as the operands |

## Verification
The hardest case to reach from the ports is a code-0 product whose normalized exponent lands on 15 with a truncated fraction of 111. That encoding would read back as NaN, so it has to be diverted to saturation. Only a narrow band of operand pairs produces it, so the bench sweeps every code-0 operand pair, with random upper bytes, and compares each result with a real-number model of the rules. Code 1 is swept over a dense lattice of pairs. Half precision gets random operands plus hand-picked NaN, infinity, overflow, underflow and carry pairs. A final phase drives random out_ready stalls with mixed formats so that results are held and resumed across back-pressure.

// File: rtl/amul_pkg.sv
package amul_pkg;

  localparam int AMUL_WORD_W = 16;
  localparam int AMUL_EXP_W  = 5;
  localparam int AMUL_FRAC_W = 10;
  localparam int AMUL_ESUM_W = AMUL_EXP_W + 3;
  localparam int AMUL_TOT_W  = AMUL_FRAC_W + 2;

  typedef enum logic [1:0] {
    FMT_E4M3   = 2'd0,
    FMT_E5M2   = 2'd1,
    FMT_HALF   = 2'd2,
    FMT_HALF_B = 2'd3
  } amul_fmt_e;

  // operand after decode: exponent right-aligned, fraction left-aligned
  typedef struct packed {
    logic                   sgn;
    logic [AMUL_EXP_W-1:0]  exp;
    logic [AMUL_FRAC_W-1:0] frac;
    logic                   is_zero;
    logic                   is_inf;
    logic                   is_nan;
  } amul_opnd_t;

  function automatic int fmt_frac_bits(amul_fmt_e f);
    case (f)
      FMT_E4M3: return 3;
      FMT_E5M2: return 2;
      default:  return AMUL_FRAC_W;
    endcase
  endfunction

  function automatic int fmt_bias(amul_fmt_e f);
    return (f == FMT_E4M3) ? 7 : 15;
  endfunction

  function automatic int fmt_emax(amul_fmt_e f);
    return (f == FMT_E4M3) ? 15 : 30;
  endfunction

  // correction exponent L chosen from the fraction width k
  function automatic int corr_exp(int k);
    if (k <= 3)      return k;
    else if (k == 4) return 3;
    else             return 4;
  endfunction

  // bit position of 2^-L inside the left-aligned fraction field
  function automatic int corr_pos(amul_fmt_e f);
    return AMUL_FRAC_W - corr_exp(fmt_frac_bits(f));
  endfunction

endpackage

// File: rtl/amul_unpack.sv
module amul_unpack
  import amul_pkg::*;
(
  input  amul_fmt_e                fmt,
  input  logic [AMUL_WORD_W-1:0]   word,
  output amul_opnd_t               opnd
);

  always_comb begin
    opnd = '0;
    case (fmt)
      FMT_E4M3: begin
        opnd.sgn    = word[7];
        opnd.exp    = {1'b0, word[6:3]};
        opnd.frac   = {word[2:0], 7'd0};
        opnd.is_nan = &word[6:0];
        opnd.is_inf = 1'b0;
      end
      FMT_E5M2: begin
        opnd.sgn    = word[7];
        opnd.exp    = word[6:2];
        opnd.frac   = {word[1:0], 8'd0};
        opnd.is_nan = (&word[6:2]) && (|word[1:0]);
        opnd.is_inf = (&word[6:2]) && !(|word[1:0]);
      end
      default: begin
        opnd.sgn    = word[AMUL_WORD_W-1];
        opnd.exp    = word[AMUL_WORD_W-2:AMUL_FRAC_W];
        opnd.frac   = word[AMUL_FRAC_W-1:0];
        opnd.is_nan = (&word[AMUL_WORD_W-2:AMUL_FRAC_W]) && (|word[AMUL_FRAC_W-1:0]);
        opnd.is_inf = (&word[AMUL_WORD_W-2:AMUL_FRAC_W]) && !(|word[AMUL_FRAC_W-1:0]);
      end
    endcase
    opnd.is_zero = (opnd.exp == '0);
  end

endmodule

// File: rtl/amul_ripple.sv
module amul_ripple #(
  parameter int W = 10
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W:0]   sum
);

  logic [W:1] cy;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_ha
      assign sum[0] = a[0] ^ b[0];
      assign cy[1]  = a[0] & b[0];
    end else begin : g_fa
      assign sum[i]  = a[i] ^ b[i] ^ cy[i];
      assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
    end
  end

  assign sum[W] = cy[W];

endmodule

// File: rtl/amul_core.sv
module amul_core
  import amul_pkg::*;
(
  input  amul_fmt_e               fmt,
  input  amul_opnd_t              opa,
  input  amul_opnd_t              opb,
  output logic [AMUL_WORD_W-1:0]  res
);

  logic [AMUL_FRAC_W:0]          fsum;
  logic [AMUL_TOT_W-1:0]         corr;
  logic [AMUL_TOT_W-1:0]         tot;
  logic                          carry;
  logic [AMUL_FRAC_W-1:0]        nfrac;
  logic signed [AMUL_ESUM_W-1:0] esum;
  logic                          sgn;
  int                            e_int;
  logic                          any_nan, any_inf, any_zero, e4_nan_hit;

  amul_ripple #(.W(AMUL_FRAC_W)) u_fadd (
    .a   (opa.frac),
    .b   (opb.frac),
    .sum (fsum)
  );

  function automatic logic [AMUL_WORD_W-1:0] nan_word(amul_fmt_e f);
    case (f)
      FMT_E4M3: return 16'h007F;
      FMT_E5M2: return 16'h007E;
      default:  return 16'h7E00;
    endcase
  endfunction

  function automatic logic [AMUL_WORD_W-1:0] zero_word(amul_fmt_e f, logic s);
    return (f == FMT_E4M3 || f == FMT_E5M2) ? {8'h00, s, 7'h00} : {s, 15'h0000};
  endfunction

  function automatic logic [AMUL_WORD_W-1:0] maxf_word(amul_fmt_e f, logic s);
    case (f)
      FMT_E4M3: return {8'h00, s, 4'hF, 3'b110};
      FMT_E5M2: return {8'h00, s, 5'h1E, 2'b11};
      default:  return {s, 5'h1E, 10'h3FF};
    endcase
  endfunction

  function automatic logic [AMUL_WORD_W-1:0] inf_word(amul_fmt_e f, logic s);
    case (f)
      FMT_E4M3: return {8'h00, s, 4'hF, 3'b110};
      FMT_E5M2: return {8'h00, s, 5'h1F, 2'b00};
      default:  return {s, 5'h1F, 10'h000};
    endcase
  endfunction

  function automatic logic [AMUL_WORD_W-1:0] norm_word(amul_fmt_e f, logic s,
                                                       logic [AMUL_EXP_W-1:0] e,
                                                       logic [AMUL_FRAC_W-1:0] fr);
    case (f)
      FMT_E4M3: return {8'h00, s, e[3:0], fr[9:7]};
      FMT_E5M2: return {8'h00, s, e[4:0], fr[9:8]};
      default:  return {s, e, fr};
    endcase
  endfunction

  // significand sum with hidden one and correction term
  always_comb begin
    corr  = AMUL_TOT_W'(1) << corr_pos(fmt);
    tot   = {1'b0, fsum} + (AMUL_TOT_W'(1) << AMUL_FRAC_W) + corr;
    carry = tot[AMUL_TOT_W-1];
    nfrac = carry ? tot[AMUL_FRAC_W:1] : tot[AMUL_FRAC_W-1:0];
  end

  // exponent adder: two fields, one bias removed, normalization carry added
  always_comb begin
    esum = AMUL_ESUM_W'(opa.exp) + AMUL_ESUM_W'(opb.exp)
         - AMUL_ESUM_W'(fmt_bias(fmt)) + AMUL_ESUM_W'(carry);
  end

  always_comb begin
    sgn        = opa.sgn ^ opb.sgn;
    e_int      = int'(esum);
    any_inf    = opa.is_inf | opb.is_inf;
    any_zero   = opa.is_zero | opb.is_zero;
    any_nan    = opa.is_nan | opb.is_nan | (any_inf & any_zero);
    e4_nan_hit = (fmt == FMT_E4M3) && (e_int == 15) && (&nfrac[9:7]);
    if (any_nan)
      res = nan_word(fmt);
    else if (any_inf)
      res = inf_word(fmt, sgn);
    else if (any_zero || e_int < 1)
      res = zero_word(fmt, sgn);
    else if (e_int > fmt_emax(fmt) || e4_nan_hit)
      res = maxf_word(fmt, sgn);
    else
      res = norm_word(fmt, sgn, esum[AMUL_EXP_W-1:0], nfrac);
  end

endmodule

// File: rtl/amul_mul.sv
module amul_mul
  import amul_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [1:0]              fmt,
  input  logic [AMUL_WORD_W-1:0]  op_a,
  input  logic [AMUL_WORD_W-1:0]  op_b,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [AMUL_WORD_W-1:0]  out_res
);

  amul_fmt_e               fmt_e;
  amul_opnd_t              dec_a, dec_b;
  logic [AMUL_WORD_W-1:0]  core_res;

  assign fmt_e = amul_fmt_e'(fmt);

  amul_unpack u_dec_a (.fmt(fmt_e), .word(op_a), .opnd(dec_a));
  amul_unpack u_dec_b (.fmt(fmt_e), .word(op_b), .opnd(dec_b));

  amul_core u_core (
    .fmt (fmt_e),
    .opa (dec_a),
    .opb (dec_b),
    .res (core_res)
  );

  if (REG_OUT) begin : g_reg
    logic                   vld_q;
    logic [AMUL_WORD_W-1:0] res_q;
    logic [1:0]             fmt_q;
    logic                   fire;

    assign in_ready  = !vld_q || out_ready;
    assign fire      = in_valid && in_ready;
    assign out_valid = vld_q;
    assign out_res   = res_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q <= 1'b0;
        res_q <= '0;
        fmt_q <= '0;
      end else begin
        if (in_ready) vld_q <= in_valid;
        if (fire) begin
          res_q <= core_res;
          fmt_q <= fmt;
        end
      end
    end

    p_lat_r10: assert property (@(posedge clk) disable iff (rst)
      fire |=> out_valid);

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_res));

    p_hibyte_r9: assert property (@(posedge clk) disable iff (rst)
      out_valid && !fmt_q[1] |-> out_res[15:8] == 8'h00);

    p_sign_r1: assert property (@(posedge clk) disable iff (rst)
      fire && !dec_a.is_nan && !dec_b.is_nan
        && !((dec_a.is_inf || dec_b.is_inf) && (dec_a.is_zero || dec_b.is_zero))
      |=> (fmt_q[1] ? out_res[15] : out_res[7]) == $past(dec_a.sgn ^ dec_b.sgn));

    p_nan_r7: assert property (@(posedge clk) disable iff (rst)
      fire && (dec_a.is_nan || dec_b.is_nan)
      |=> out_res == ((fmt_q == 2'd0) ? 16'h007F : (fmt_q == 2'd1) ? 16'h007E : 16'h7E00));

    p_fin_r5: assert property (@(posedge clk) disable iff (rst)
      fire && fmt == 2'd0 && !dec_a.is_nan && !dec_b.is_nan |=> out_res[6:0] != 7'h7F);

    p_zero_r4: assert property (@(posedge clk) disable iff (rst)
      fire && (dec_a.is_zero || dec_b.is_zero) && !dec_a.is_nan && !dec_b.is_nan
        && !dec_a.is_inf && !dec_b.is_inf
      |=> (fmt_q[1] ? out_res[14:0] == 15'h0 : out_res[6:0] == 7'h0));
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_res   = core_res;
  end

endmodule

// File: tb/sim_amul_mul.sv
module sim_amul_mul;

  localparam int CLK_P    = 10;
  localparam int WDOG_CYC = 190000;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [1:0]  fmt;
  logic [15:0] op_a, op_b;
  logic        out_valid;
  logic        out_ready;
  logic [15:0] out_res;

  amul_mul u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .fmt(fmt),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_res(out_res)
  );

  always #(CLK_P/2) clk = ~clk;

  int          checks = 0;
  int          bad    = 0;
  bit          done   = 1'b0;
  bit          stall_en = 1'b0;
  bit          prev_hold = 1'b0;
  logic [15:0] prev_res;
  logic [31:0] rng = 32'h1234_5679;
  logic [15:0] expq[$];
  string       tagq[$];
  logic [15:0] inq[$];

  task automatic step_rng();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
  endtask

  task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp, string what);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // model built from the requirement text, using real arithmetic
  function automatic logic [15:0] ref_mul(input logic [1:0] f, input logic [15:0] a,
                                          input logic [15:0] b, output string tag);
    int k, ew, bias, emax, av, bv, sa, sb, ea, eb, fa, fb, s, sh, ll, e, fr, emask, fmask;
    bit nan_a, nan_b, inf_a, inf_b, zr_a, zr_b;
    real m;
    k     = (f == 2'd0) ? 3 : (f == 2'd1) ? 2 : 10;
    ew    = (f == 2'd0) ? 4 : 5;
    bias  = (f == 2'd0) ? 7 : 15;
    emax  = (f == 2'd0) ? 15 : 30;
    emask = (1 << ew) - 1;
    fmask = (1 << k) - 1;
    sh    = k + ew;
    av    = f[1] ? int'(a) : int'(a[7:0]);
    bv    = f[1] ? int'(b) : int'(b[7:0]);
    sa = (av >> sh) & 1; sb = (bv >> sh) & 1;
    ea = (av >> k) & emask; eb = (bv >> k) & emask;
    fa = av & fmask; fb = bv & fmask;
    s  = sa ^ sb;
    if (f == 2'd0) begin
      nan_a = (ea == 15) && (fa == 7); nan_b = (eb == 15) && (fb == 7);
      inf_a = 1'b0; inf_b = 1'b0;
    end else begin
      nan_a = (ea == 31) && (fa != 0); nan_b = (eb == 31) && (fb != 0);
      inf_a = (ea == 31) && (fa == 0); inf_b = (eb == 31) && (fb == 0);
    end
    zr_a = (ea == 0); zr_b = (eb == 0);
    if (nan_a || nan_b || ((inf_a || inf_b) && (zr_a || zr_b))) begin
      tag = "R7";
      return (f == 2'd0) ? 16'h007F : (f == 2'd1) ? 16'h007E : 16'h7E00;
    end
    if (inf_a || inf_b) begin
      tag = "R8";
      return 16'((s << sh) | (emask << k));
    end
    if (zr_a || zr_b) begin
      tag = "R4";
      return 16'(s << sh);
    end
    ll = (k <= 3) ? k : (k == 4) ? 3 : 4;
    m  = 1.0 + real'(fa) / real'(1 << k) + real'(fb) / real'(1 << k) + 1.0 / real'(1 << ll);
    e  = ea + eb - bias;
    tag = "R2";
    if (m >= 2.0) begin
      m = m / 2.0;
      e = e + 1;
      tag = "R3";
    end
    fr = int'($floor((m - 1.0) * real'(1 << k)));
    if (e < 1) begin
      tag = "R6";
      return 16'(s << sh);
    end
    if (e > emax || (f == 2'd0 && e == 15 && fr == 7)) begin
      tag = "R5";
      return (f == 2'd0) ? 16'((s << 7) | 8'h7E) : 16'((s << sh) | (30 << k) | fmask);
    end
    return 16'((s << sh) | (e << k) | fr);
  endfunction

  // one sampled cycle: handshake checks, then bookkeeping of accept and take
  task automatic observe(output bit accepted);
    logic [15:0] e;
    logic [15:0] ai;
    string       t;
    chk(out_valid == (expq.size() != 0), "R10", 16'(out_valid), 16'(expq.size() != 0),
        "result not offered exactly one cycle after accept");
    chk(in_ready == (!out_valid || out_ready), "R10", 16'(in_ready),
        16'(!out_valid || out_ready), "in_ready rule");
    if (prev_hold)
      chk(out_valid && out_res == prev_res, "R11", out_res, prev_res, "held result changed");
    if (out_valid && out_ready && expq.size() != 0) begin
      e  = expq.pop_front();
      t  = tagq.pop_front();
      ai = inq.pop_front();
      chk(out_res == e, t, out_res, e, $sformatf("(R1/R9 incl.) operands tag=%h", ai));
    end
    prev_hold = out_valid && !out_ready;
    prev_res  = out_res;
    accepted  = in_valid && in_ready;
    if (accepted) begin
      expq.push_back(ref_mul(fmt, op_a, op_b, t));
      tagq.push_back(t);
      inq.push_back({op_a[7:0], op_b[7:0]});
    end
  endtask

  task automatic xfer(input logic [1:0] f, input logic [15:0] a, input logic [15:0] b);
    bit acc;
    do begin
      @(negedge clk);
      in_valid  = 1'b1;
      fmt       = f;
      op_a      = a;
      op_b      = b;
      out_ready = stall_en ? rng[7] : 1'b1;
      step_rng();
      #1;
      observe(acc);
    end while (!acc);
  endtask

  task automatic idle_cycles(input int n);
    bit acc;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid  = 1'b0;
      out_ready = 1'b1;
      #1;
      observe(acc);
    end
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", checks, bad);
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog expired act=%h exp=%h", 16'h0, 16'h1);
      report();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1; fmt = 2'd0; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R12", 16'(out_valid), 16'h0, "out_valid in reset");
    chk(in_ready == 1'b1, "R12", 16'(in_ready), 16'h1, "in_ready in reset");
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R12", 16'(out_valid), 16'h0, "out_valid after reset");

    // code 0: every operand pair, upper bytes random (R9)
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++) begin
        xfer(2'd0, {rng[15:8], 8'(a)}, {rng[23:16], 8'(b)});
      end

    // code 1: dense lattice
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 3)
        xfer(2'd1, {rng[15:8], 8'(a)}, {rng[31:24], 8'(b)});

    // half precision corner pairs
    xfer(2'd2, 16'h7E00, 16'h3C00);  // R7 NaN in
    xfer(2'd2, 16'h7C00, 16'h0000);  // R7 inf * zero
    xfer(2'd2, 16'hFC00, 16'h4000);  // R8 negative inf
    xfer(2'd2, 16'h7C00, 16'hFC00);  // R8 inf * inf
    xfer(2'd2, 16'h7BFF, 16'h7BFF);  // R5 overflow
    xfer(2'd2, 16'hFBFF, 16'h7BFF);  // R5 negative overflow
    xfer(2'd2, 16'h0400, 16'h0400);  // R6 underflow
    xfer(2'd2, 16'h3FFF, 16'h3FFF);  // R3 carry
    xfer(2'd2, 16'h0001, 16'h3C00);  // R4 subnormal flush
    xfer(2'd2, 16'h8000, 16'h3C00);  // R4 negative zero
    xfer(2'd2, 16'h3C00, 16'hBC00);  // R1/R2 -1.0625
    xfer(2'd1, 16'h007C, 16'h0080);  // R7 code 1 inf * -0
    xfer(2'd0, 16'h007F, 16'h0038);  // R7 code 0 NaN

    // half precision random
    for (int i = 0; i < 16000; i++) begin
      xfer(2'd2, rng[15:0], rng[31:16]);
      step_rng();
    end
    for (int i = 0; i < 1500; i++) begin
      xfer(2'd3, rng[15:0], rng[31:16]);
      step_rng();
    end

    // back-pressure, mixed formats (R11)
    stall_en = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      xfer(rng[9:8], rng[31:16], {rng[7:0], rng[23:16]});
      step_rng();
    end
    stall_en = 1'b0;
    idle_cycles(4);
    chk(expq.size() == 0, "R10", 16'(expq.size()), 16'h0, "results left undelivered");

    done = 1'b1;
    report();
    $finish;
  end

endmodule